// File: doc/BRIEF.md
# Multiplexed-Address DRAM Sequencer with CAS-before-RAS Refresh

This block connects a byte-wide host request stream to an asynchronous DRAM module whose address pins carry the row address and then the column address. A host request names one byte by a 24-bit linear address and is either a read or a write. The block splits that address into a row half and a column half. It then steps the active-low row strobe, column strobe and write enable through the order the memory expects, and holds each strobe level for a programmable number of clocks. The data bus is given as separate in and out vectors plus an output enable, so the pad ring can build the tri-state buffer.

An internal interval timer asks for a refresh at a fixed period. A refresh is a CAS-before-RAS cycle and needs no address. It is never started in the middle of a host access. A request that comes due during an access waits and runs as soon as the access has closed. A refresh that has already begun runs to its end before the next host request is taken. The address-line count sets the capacity: 9, 10, 11 or 12 lines give 256K, 1M, 4M or 16M bytes. Linear address bits at or above twice the line count are dropped, so higher addresses wrap onto low memory.

The request side is a valid/ready stream. A request is transferred in a cycle where `req_valid` and `req_ready` are both high. The host must hold its request fields stable while it waits. `req_ready` is high only when no access or refresh is running and no refresh is waiting. The response is a one-cycle `rsp_done` pulse that cannot be stalled. With it come `rsp_rdata` for a read and the fall of `busy`.

Top module: `dram_mux_ctrl`

## Requirements
- R1: The row address is linear bits [7:0] in row bits 7..0, followed by linear bits 16, 18, 20 and 22 in row bits 8, 9, 10 and 11. The column address is linear bits [15:8] in column bits 7..0, followed by linear bits 17, 19, 21 and 23 in column bits 8 to 11. Only ADDR_LINES bits of each are driven. Linear bits at or above position 2*ADDR_LINES have no effect.
- R2: A read drops RAS while the row is on the bus and then drops CAS while the column is on the bus. WE stays high the whole time. The byte on `mem_dq_i` is captured before CAS and RAS rise together, and it is returned on `rsp_rdata`.
- R3: A write uses early-write order. RAS falls first. WE then falls while CAS is still high. CAS falls with the column on the bus. WE rises while CAS is still low. RAS and CAS then rise together. WE is low only while RAS is low.
- R4: After any edge of RAS, CAS or WE, no other edge of these three strobes follows within SETTLE_CYC clocks.
- R5: `mem_dq_oe` is high only while WE is low. While the column strobe falls in a write, `mem_dq_o` carries the request's write byte.
- R6: A refresh drops CAS while RAS is high, then drops RAS, then raises RAS, then raises CAS, with WE held high throughout. Refreshes come once per REFRESH_INTERVAL clocks.
- R7: A refresh never starts while `busy` is high. A refresh that comes due during an access starts within one access time of its due point. A running refresh holds `req_ready` low until it ends.
- R8: `req_ready` is high only when idle with no refresh waiting. `busy` rises in the cycle after the transfer and falls when all strobes are high again. `rsp_done` is a one-cycle pulse. It comes 5*SETTLE_CYC+1 clocks after the transfer edge for a read and 8*SETTLE_CYC+1 clocks after it for a write.
- R9: After reset, RAS, CAS and WE are high, `mem_dq_oe`, `busy` and `rsp_done` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Linear byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte read, valid with rsp_done of a read |
| busy | output | 1 | Host access in progress |
| mem_addr | output | ADDR_LINES | Multiplexed row/column address |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_o | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 8 | Data from the memory |

## Verification
A wrong sequencer state shows up at the strobe pins in the very next cycle. It appears as a misordered edge, edges closer together than the settle count, WE low outside a row cycle, or a drive enable while WE is high. The bench's pin-level memory model catches these at the edge where they happen. A bad address split or latched-address error shows up when the column strobe falls, as a row or column value different from the expected mapping. A lost or stuck refresh request shows up within one refresh interval, as a gap between refresh cycles that is too long or as the wrong number of refreshes in an idle window. A wrong capture or commit is seen at the next read of the same location, through rsp_rdata.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ROW,
    ST_RAS,
    ST_WEL,
    ST_DAT,
    ST_COL,
    ST_CAS,
    ST_WEH,
    ST_REL,
    ST_RF_CAS,
    ST_RF_RAS,
    ST_RF_RUP,
    ST_RF_END
  } seq_state_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic oe;
    logic use_col;
    logic host;
  } pin_ctl_t;

  function automatic pin_ctl_t ctl_of(seq_state_e s, logic wr);
    pin_ctl_t c;
    c = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, oe: 1'b0, use_col: 1'b0, host: 1'b0};
    case (s)
      ST_ROW:    c.host = 1'b1;
      ST_RAS:    begin c.host = 1'b1; c.ras_n = 1'b0; end
      ST_WEL:    begin c.host = 1'b1; c.ras_n = 1'b0; c.we_n = 1'b0; end
      ST_DAT:    begin c.host = 1'b1; c.ras_n = 1'b0; c.we_n = 1'b0; c.oe = 1'b1; end
      ST_COL:    begin
                   c.host = 1'b1; c.ras_n = 1'b0; c.use_col = 1'b1;
                   c.we_n = ~wr; c.oe = wr;
                 end
      ST_CAS:    begin
                   c.host = 1'b1; c.ras_n = 1'b0; c.cas_n = 1'b0; c.use_col = 1'b1;
                   c.we_n = ~wr; c.oe = wr;
                 end
      ST_WEH:    begin c.host = 1'b1; c.ras_n = 1'b0; c.cas_n = 1'b0; c.use_col = 1'b1; end
      ST_REL:    begin c.host = 1'b1; c.use_col = 1'b1; end
      ST_RF_CAS: c.cas_n = 1'b0;
      ST_RF_RAS: begin c.cas_n = 1'b0; c.ras_n = 1'b0; end
      ST_RF_RUP: c.cas_n = 1'b0;
      default:   ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/dram_addr_split.sv
module dram_addr_split #(
  parameter int ADDR_LINES = 12
) (
  input  logic [23:0]           lin_addr,
  output logic [ADDR_LINES-1:0] row,
  output logic [ADDR_LINES-1:0] col
);
  localparam int HI_BITS = ADDR_LINES - 8;

  logic spare_unused;
  assign spare_unused = ^lin_addr;

  assign row[7:0] = lin_addr[7:0];
  assign col[7:0] = lin_addr[15:8];

  // high byte interleaves: even bits to the row, odd bits to the column
  for (genvar i = 0; i < HI_BITS; i++) begin : g_hi
    assign row[8+i] = lin_addr[16+2*i];
    assign col[8+i] = lin_addr[17+2*i];
  end

endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int INTERVAL = 260
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  output logic pending
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q;
  logic          tick;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pending <= 1'b0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (tick)
        pending <= 1'b1;
      else if (take)
        pending <= 1'b0;
    end
  end

  // R7
  no_lost_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !take |=> pending);

  // R6
  take_only_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> pending);

endmodule

// File: rtl/dram_strobe_fsm.sv
module dram_strobe_fsm
  import dram_mux_pkg::*;
#(
  parameter int SETTLE_CYC = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  logic     req_write,
  input  logic     rf_pending,
  input  logic [7:0] mem_dq_i,
  output logic     req_ready,
  output logic     accept,
  output logic     rf_take,
  output pin_ctl_t ctl,
  output logic [7:0] rdata,
  output logic     done,
  output logic     busy
);
  localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(SETTLE_CYC - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_q;
  logic             adv;

  assign adv       = (cnt_q == '0);
  assign req_ready = (state_q == ST_IDLE) && !rf_pending;
  assign busy      = ctl.host;

  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    rf_take = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (rf_pending) begin
          state_d = ST_RF_CAS;
          rf_take = 1'b1;
        end else if (req_valid) begin
          state_d = ST_ROW;
          accept  = 1'b1;
        end
      end
      ST_ROW:    if (adv) state_d = ST_RAS;
      ST_RAS:    if (adv) state_d = wr_q ? ST_WEL : ST_COL;
      ST_WEL:    if (adv) state_d = ST_DAT;
      ST_DAT:    if (adv) state_d = ST_COL;
      ST_COL:    if (adv) state_d = ST_CAS;
      ST_CAS:    if (adv) state_d = wr_q ? ST_WEH : ST_REL;
      ST_WEH:    if (adv) state_d = ST_REL;
      ST_REL:    if (adv) state_d = ST_IDLE;
      ST_RF_CAS: if (adv) state_d = ST_RF_RAS;
      ST_RF_RAS: if (adv) state_d = ST_RF_RUP;
      ST_RF_RUP: if (adv) state_d = ST_RF_END;
      ST_RF_END: if (adv) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= CNT_INIT;
      wr_q    <= 1'b0;
      ctl     <= ctl_of(ST_IDLE, 1'b0);
      rdata   <= '0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q)
        cnt_q <= CNT_INIT;
      else if (!adv)
        cnt_q <= cnt_q - 1'b1;
      if (accept)
        wr_q <= req_write;
      ctl <= ctl_of(state_d, accept ? req_write : wr_q);
      if (state_q == ST_CAS && adv && !wr_q)
        rdata <= mem_dq_i;
      done <= (state_q == ST_REL) && adv;
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy && ctl.ras_n && ctl.cas_n && ctl.we_n);

  // R7
  rf_not_during_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl.cas_n) && ctl.ras_n |-> !busy);

endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl
  import dram_mux_pkg::*;
#(
  parameter int ADDR_LINES       = 12,
  parameter int SETTLE_CYC       = 2,
  parameter int REFRESH_INTERVAL = 260
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [23:0]           req_addr,
  input  logic [7:0]            req_wdata,
  output logic                  rsp_done,
  output logic [7:0]            rsp_rdata,
  output logic                  busy,
  output logic [ADDR_LINES-1:0] mem_addr,
  output logic                  mem_ras_n,
  output logic                  mem_cas_n,
  output logic                  mem_we_n,
  output logic [7:0]            mem_dq_o,
  output logic                  mem_dq_oe,
  input  logic [7:0]            mem_dq_i
);
  logic [ADDR_LINES-1:0] row_w, col_w, row_q, col_q;
  logic [7:0]            wdata_q;
  logic                  accept, rf_take, rf_pending;
  pin_ctl_t              ctl;

  dram_addr_split #(.ADDR_LINES(ADDR_LINES)) u_split (
    .lin_addr (req_addr),
    .row      (row_w),
    .col      (col_w)
  );

  dram_refresh_timer #(.INTERVAL(REFRESH_INTERVAL)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (rf_take),
    .pending (rf_pending)
  );

  dram_strobe_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .rf_pending (rf_pending),
    .mem_dq_i   (mem_dq_i),
    .req_ready  (req_ready),
    .accept     (accept),
    .rf_take    (rf_take),
    .ctl        (ctl),
    .rdata      (rsp_rdata),
    .done       (rsp_done),
    .busy       (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q   <= '0;
      col_q   <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      row_q   <= row_w;
      col_q   <= col_w;
      wdata_q <= req_wdata;
    end
  end

  assign mem_addr  = ctl.use_col ? col_q : row_q;
  assign mem_ras_n = ctl.ras_n;
  assign mem_cas_n = ctl.cas_n;
  assign mem_we_n  = ctl.we_n;
  assign mem_dq_oe = ctl.oe;
  assign mem_dq_o  = wdata_q;

  // R5
  oe_within_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_we_n && !mem_ras_n);

  // R3
  we_inside_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ras_n);

  // R6
  cbr_we_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cas_n && mem_ras_n |-> mem_we_n);

  // R2
  rise_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ras_n) && busy |-> $rose(mem_cas_n));

  if (SETTLE_CYC >= 2) begin : g_settle
    // R4
    strobe_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mem_ras_n) || $fell(mem_ras_n) || $rose(mem_cas_n) || $fell(mem_cas_n)
       || $rose(mem_we_n) || $fell(mem_we_n))
      |=> $stable(mem_ras_n) && $stable(mem_cas_n) && $stable(mem_we_n));
  end

endmodule

// File: tb/dram_mux_ctrl_bench.sv
module dram_mux_ctrl_bench;
  localparam int AL = 10;
  localparam int S  = 2;
  localparam int RI = 80;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [23:0]   req_addr = '0;
  logic [7:0]    req_wdata = '0;
  logic          req_ready, rsp_done, busy;
  logic [7:0]    rsp_rdata;
  logic [AL-1:0] mem_addr;
  logic          mem_ras_n, mem_cas_n, mem_we_n, mem_dq_oe;
  logic [7:0]    mem_dq_o, mem_dq_i;

  always #2 clk = ~clk;

  dram_mux_ctrl #(.ADDR_LINES(AL), .SETTLE_CYC(S), .REFRESH_INTERVAL(RI)) u_dram_mux_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .busy(busy),
    .mem_addr(mem_addr), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
    .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int f_row(logic [23:0] a);
    int r = int'(a[7:0]);
    for (int i = 0; i < AL - 8; i++) r = r | (int'(a[16+2*i]) << (8 + i));
    return r;
  endfunction

  function automatic int f_col(logic [23:0] a);
    int r = int'(a[15:8]);
    for (int i = 0; i < AL - 8; i++) r = r | (int'(a[17+2*i]) << (8 + i));
    return r;
  endfunction

  function automatic int f_key(logic [23:0] a);
    return int'(a) & ((1 << (2 * AL)) - 1);
  endfunction

  // pin-level memory model
  logic [7:0] dmem [int];
  logic [7:0] exp_mem [int];
  logic [23:0] cur_addr = '0;
  logic [7:0]  cur_wdata = '0;
  logic [7:0]  dq_drv = '0;
  logic        dq_en = 1'b0;
  assign mem_dq_i = dq_en ? dq_drv : 8'h00;

  logic ras_p = 1'b1, cas_p = 1'b1, we_p = 1'b1;
  int   row_lat = 0, last_edge = -1000, last_cbr = -1, rf_count = 0;
  bit   in_cbr = 0;

  always @(negedge clk) if (rst_n) begin
    bit ev;
    ev = (mem_ras_n != ras_p) || (mem_cas_n != cas_p) || (mem_we_n != we_p);
    if (ev) begin
      // R4 settle spacing between strobe edges
      chk(cyc - last_edge >= S, "R4 edge spacing", cyc - last_edge, S);
      last_edge = cyc;
    end
    // R5 drive only while WE low
    if (mem_dq_oe && mem_we_n) chk(0, "R5 oe with WE high", 1, 0);
    // R7 no ready or busy while refresh runs
    if (in_cbr && (req_ready || busy)) chk(0, "R7 ready/busy during refresh", {req_ready, busy}, 0);

    if (!mem_cas_n && cas_p) begin
      if (mem_ras_n) begin
        // R6 CBR start
        in_cbr = 1;
        chk(mem_we_n == 1'b1, "R6 WE high at CBR", mem_we_n, 1);
        chk(!busy, "R7 refresh starts while busy", busy, 0);
        if (last_cbr >= 0)
          chk(cyc - last_cbr <= RI + 8 * S + 4, "R7 refresh gap", cyc - last_cbr, RI + 8 * S + 4);
        last_cbr = cyc;
        rf_count++;
      end else begin
        int c, key;
        c = int'(mem_addr);
        chk(row_lat == f_row(cur_addr), "R1 row address", row_lat, f_row(cur_addr));
        chk(c == f_col(cur_addr), "R1 column address", c, f_col(cur_addr));
        key = (row_lat << AL) | c;
        if (!mem_we_n) begin
          chk(mem_dq_oe && mem_dq_o == cur_wdata, "R5 write data at CAS", mem_dq_o, cur_wdata);
          dmem[key] = mem_dq_o;
        end else begin
          dq_drv = dmem.exists(key) ? dmem[key] : 8'h00;
          dq_en = 1;
        end
      end
    end
    if (!mem_ras_n && ras_p) begin
      if (!mem_cas_n) chk(in_cbr, "R6 RAS falls after CAS", in_cbr, 1);
      else row_lat = int'(mem_addr);
    end
    if (!mem_we_n && we_p)
      chk(!mem_ras_n && mem_cas_n, "R3 WE falls in row before CAS", {mem_ras_n, mem_cas_n}, 1);
    if (mem_we_n && !we_p)
      chk(!mem_cas_n, "R3 WE rises while CAS low", mem_cas_n, 0);
    if (mem_ras_n && !ras_p) begin
      if (in_cbr) chk(!mem_cas_n, "R6 RAS rises before CAS", mem_cas_n, 0);
      else chk(mem_cas_n && !cas_p, "R2 CAS and RAS rise together", mem_cas_n, 1);
    end
    if (mem_cas_n && !cas_p) begin
      if (in_cbr) chk(mem_ras_n, "R6 CAS rises last", mem_ras_n, 1);
      in_cbr = 0;
      dq_en = 0;
    end
    ras_p = mem_ras_n; cas_p = mem_cas_n; we_p = mem_we_n;
  end

  task automatic do_access(input bit wr, input logic [23:0] a, input logic [7:0] d);
    int n, lim, key;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    cur_addr = a; cur_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr = 24'($urandom);
    chk(busy, "R8 busy after transfer", busy, 1);
    n = 1;
    while (!rsp_done && n < 200) begin @(negedge clk); n++; end
    lim = (wr ? 8 * S : 5 * S) + 1;
    chk(n == lim, "R8 done latency", n, lim);
    chk(!busy && mem_ras_n && mem_cas_n, "R8 busy low at done", busy, 0);
    key = f_key(a);
    if (wr) exp_mem[key] = d;
    else begin
      int e;
      e = exp_mem.exists(key) ? int'(exp_mem[key]) : 0;
      chk(int'(rsp_rdata) == e, "R2 read data", rsp_rdata, e);
    end
  endtask

  logic [23:0] pool [16];

  initial begin : wd
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int r0;
    void'($urandom(32'd7719));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(mem_ras_n && mem_cas_n && mem_we_n, "R9 strobes high in reset", {mem_ras_n, mem_cas_n, mem_we_n}, 7);
    chk(!mem_dq_oe && !busy && !rsp_done, "R9 outputs low in reset", {mem_dq_oe, busy, rsp_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R9 ready after reset", req_ready, 1);

    // directed: write/read, rollover (R1)
    do_access(1, 24'h012345, 8'h5A);
    do_access(0, 24'h012345, 8'h00);
    do_access(0, 24'hF12345, 8'h00);   // R1 bits 20..23 ignored at AL=10
    do_access(1, 24'hAFFFFF, 8'hC3);
    do_access(0, 24'h0FFFFF, 8'h00);   // R1 wraps onto same location
    do_access(1, 24'h000000, 8'h11);
    do_access(0, 24'h000000, 8'h00);

    // R6 idle window refresh count
    r0 = rf_count;
    repeat (8 * RI) @(negedge clk);
    chk(rf_count - r0 >= 7 && rf_count - r0 <= 9, "R6 refresh rate", rf_count - r0, 8);

    // random traffic over a small address pool
    for (int i = 0; i < 16; i++) pool[i] = 24'($urandom);
    for (int i = 0; i < 300; i++) begin
      int gap;
      do_access(1'($urandom), pool[$urandom % 16], 8'($urandom));
      gap = ($urandom % 4 == 0) ? int'($urandom % 20) : 0;
      repeat (gap) @(negedge clk);
    end
    // back-to-back reads: refresh must still interleave (R7)
    r0 = rf_count;
    for (int i = 0; i < 40; i++) do_access(0, pool[i % 16], 8'h00);
    chk(rf_count > r0, "R7 refresh between accesses", rf_count - r0, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule